// File: doc/BRIEF.md
# Four-Lane Bidirectional Serial-to-Parallel Column Driver

This block turns four serial bit streams into a 64-bit parallel word for driving display columns. Four 16-stage shift registers share one clock and advance together on its rising edge, so four bits enter per clock. A direction input picks which end of each lane takes the serial bit. The stages feed a bank of level-sensitive latches, which are transparent while the latch enable is high and hold their contents while it is low.

Between the latches and the 64 outputs sits gating for blanking and polarity. Blanking drives every output low. Polarity inversion flips every output. A cascade output shows the last stage of lane 3 in the current direction, so that several of these blocks can be chained. An asynchronous active-low reset clears every stage and latch.

Top module: `quad_sipo_driver`

## Requirements
- R1: With dirRev low, on each rising clock edge stage 0 of lane r (r = 0..3) loads dinLanes[r]. Stage s (s = 1..15) loads the old value of stage s-1.
- R2: With dirRev high, on each rising clock edge stage 15 of lane r loads dinLanes[r]. Stage s (s = 0..14) loads the old value of stage s+1.
- R3: Output bit pout[4*s + r] (0-based) is driven from stage s of lane r through its latch. pout[63] therefore comes from stage 15 of lane 3.
- R4: dataOut equals stage 15 of lane 3 when dirRev is low and stage 0 of lane 3 when dirRev is high. latchEn, blankN and polN have no effect on it.
- R5: While latchEn is high, each latch follows its stage. While latchEn is low, the latches hold their last value even as the stages keep shifting.
- R6: blankN is active low. While it is low, all 64 outputs are 0, whatever the latch contents and polN.
- R7: polN is active low. With blankN high and polN low, each output is the inverse of its latch bit. With blankN high and polN high, each output equals its latch bit.
- R8: rstN low asynchronously clears all shift stages and all latches to 0.
- R9: Shifting proceeds on every clock edge regardless of latchEn, blankN and polN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| dinLanes | input | 4 | Serial data, one bit per lane |
| dirRev | input | 1 | 0: shift toward stage 15, 1: shift toward stage 0 |
| latchEn | input | 1 | 1: latches transparent, 0: latches hold |
| blankN | input | 1 | Active-low blank, forces all outputs low |
| polN | input | 1 | Active-low polarity, inverts outputs |
| pout | output | 64 | Parallel column outputs |
| dataOut | output | 1 | Cascade output, last stage of lane 3 |

## Verification
The following port relations are checked on every cycle:
- Blanking gives zero outputs.
- The cascade bit matches the output behind it in each direction.
- Serial bits appear at the entry outputs one edge later while the latches are open.
- The outputs stay frozen while the latches are closed and the gating is neutral.

The bench's scenarios cover the rest:
- The full interleaved mapping of all 64 outputs.
- Inversion under polarity.
- Hold followed by a reopened latch revealing data that shifted in meanwhile.
- Reset in the middle of a run.

// File: rtl/spd_pkg.sv
package spd_pkg;
  typedef struct packed {
    logic shiftRev;   // lanes shift toward stage 0
    logic latchOpen;  // latch bank transparent
    logic forceLow;   // all outputs driven low
    logic invert;     // outputs are inverse of latch bits
  } ctrlStrobes_t;
endpackage

// File: rtl/spd_ctrl.sv
module spd_ctrl
  import spd_pkg::*;
(
  input  logic         dirRev,
  input  logic         latchEn,
  input  logic         blankN,
  input  logic         polN,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.shiftRev  = dirRev;
    strobes.latchOpen = latchEn;
    strobes.forceLow  = !blankN;
    strobes.invert    = blankN && !polN;
  end
endmodule

// File: rtl/spd_lane.sv
module spd_lane #(
  parameter int STAGES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  logic              shiftRev,
  input  logic              latchOpen,
  output logic [STAGES-1:0] stageQ,
  output logic [STAGES-1:0] latchQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      stageQ <= '0;
    else if (shiftRev)
      stageQ <= {serIn, stageQ[STAGES-1:1]};
    else
      stageQ <= {stageQ[STAGES-2:0], serIn};
  end

  always_latch begin
    if (!rstN)
      latchQ <= '0;
    else if (latchOpen)
      latchQ <= stageQ;
  end
endmodule

// File: rtl/spd_datapath.sv
module spd_datapath
  import spd_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int STAGES = 16,
  localparam int WIDTH = LANES * STAGES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] dinLanes,
  input  ctrlStrobes_t     strobes,
  output logic [WIDTH-1:0] pout,
  output logic             dataOut
);
  logic [STAGES-1:0] stageQ [LANES];
  logic [STAGES-1:0] latchQ [LANES];

  for (genvar r = 0; r < LANES; r++) begin : g_lane
    spd_lane #(.STAGES(STAGES)) u_lane (
      .clk      (clk),
      .rstN     (rstN),
      .serIn    (dinLanes[r]),
      .shiftRev (strobes.shiftRev),
      .latchOpen(strobes.latchOpen),
      .stageQ   (stageQ[r]),
      .latchQ   (latchQ[r])
    );
    for (genvar s = 0; s < STAGES; s++) begin : g_bit
      always_comb begin
        if (strobes.forceLow)
          pout[s*LANES + r] = 1'b0;
        else
          pout[s*LANES + r] = latchQ[r][s] ^ strobes.invert;
      end
    end
  end

  assign dataOut = strobes.shiftRev ? stageQ[LANES-1][0] : stageQ[LANES-1][STAGES-1];
endmodule

// File: rtl/quad_sipo_driver.sv
module quad_sipo_driver
  import spd_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int STAGES = 16,
  localparam int WIDTH = LANES * STAGES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] dinLanes,
  input  logic             dirRev,
  input  logic             latchEn,
  input  logic             blankN,
  input  logic             polN,
  output logic [WIDTH-1:0] pout,
  output logic             dataOut
);
  ctrlStrobes_t strobes;

  spd_ctrl u_ctrl (
    .dirRev (dirRev),
    .latchEn(latchEn),
    .blankN (blankN),
    .polN   (polN),
    .strobes(strobes)
  );

  spd_datapath #(.LANES(LANES), .STAGES(STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .dinLanes(dinLanes),
    .strobes (strobes),
    .pout    (pout),
    .dataOut (dataOut)
  );
endmodule

// File: rtl/spd_checker.sv
module spd_checker #(
  parameter int LANES  = 4,
  parameter int STAGES = 16,
  localparam int WIDTH = LANES * STAGES
) (
  input logic             clk,
  input logic             rstN,
  input logic [LANES-1:0] dinLanes,
  input logic             dirRev,
  input logic             latchEn,
  input logic             blankN,
  input logic             polN,
  input logic [WIDTH-1:0] pout,
  input logic             dataOut
);
  logic neutralOpen;
  assign neutralOpen = latchEn && blankN && polN;

  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !blankN |-> (pout == '0)); // R6

  AST_CASCADE_FWD: assert property (@(posedge clk) disable iff (!rstN)
    (!dirRev && neutralOpen) |-> (dataOut == pout[WIDTH-1])); // R4

  AST_CASCADE_REV: assert property (@(posedge clk) disable iff (!rstN)
    (dirRev && neutralOpen) |-> (dataOut == pout[LANES-1])); // R4

  AST_FWD_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (!dirRev && neutralOpen) |=>
      (!(!dirRev && neutralOpen) || (pout[LANES-1:0] == $past(dinLanes)))); // R1

  AST_REV_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (dirRev && neutralOpen) |=>
      (!(dirRev && neutralOpen) || (pout[WIDTH-1:WIDTH-LANES] == $past(dinLanes)))); // R2

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!latchEn && blankN && polN) && !latchEn && blankN && polN) |-> $stable(pout)); // R5
endmodule

bind quad_sipo_driver spd_checker #(.LANES(LANES), .STAGES(STAGES)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .dinLanes(dinLanes),
  .dirRev  (dirRev),
  .latchEn (latchEn),
  .blankN  (blankN),
  .polN    (polN),
  .pout    (pout),
  .dataOut (dataOut)
);

// File: tb/quad_sipo_driver_bench.sv
`timescale 1ns/1ps
module quad_sipo_driver_bench;
  localparam int L = 4;
  localparam int S = 16;
  localparam int W = L * S;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [L-1:0] dinLanes = '0;
  logic dirRev = 1'b0, latchEn = 1'b0, blankN = 1'b1, polN = 1'b1;
  logic [W-1:0] pout;
  logic dataOut;

  int nChecks = 0;
  int nFails = 0;
  logic [S-1:0] mSr [L];
  logic [S-1:0] mLat [L];

  always #2.5 clk = ~clk;

  quad_sipo_driver u_quad_sipo_driver (
    .clk(clk), .rstN(rstN), .dinLanes(dinLanes), .dirRev(dirRev),
    .latchEn(latchEn), .blankN(blankN), .polN(polN),
    .pout(pout), .dataOut(dataOut)
  );

  function automatic logic [W-1:0] expOut();
    logic [W-1:0] v;
    for (int s = 0; s < S; s++)
      for (int r = 0; r < L; r++) begin
        if (!blankN) v[s*L + r] = 1'b0;
        else if (!polN) v[s*L + r] = ~mLat[r][s];
        else v[s*L + r] = mLat[r][s];
      end
    return v;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int r = 0; r < L; r++) begin
      mSr[r] = '0;
      mLat[r] = '0;
    end
  endtask

  // One clock: drive at negedge, update model at posedge, compare after it.
  task automatic step(input logic [L-1:0] d, input logic dr, input logic le,
                      input logic bl, input logic pl);
    string tag;
    @(negedge clk);
    dinLanes = d; dirRev = dr; latchEn = le; blankN = bl; polN = pl;
    @(posedge clk);
    for (int r = 0; r < L; r++)
      mSr[r] = dr ? {d[r], mSr[r][S-1:1]} : {mSr[r][S-2:0], d[r]};
    #1;
    if (le) for (int r = 0; r < L; r++) mLat[r] = mSr[r];
    if (!bl) tag = "R6";
    else if (!pl) tag = "R7";
    else if (!le) tag = "R5";
    else tag = dr ? "R2/R3" : "R1/R3";
    check(tag, pout, expOut());
    check("R4", {{(W-1){1'b0}}, dataOut},
          {{(W-1){1'b0}}, (dr ? mSr[L-1][0] : mSr[L-1][S-1])});
  endtask

  initial begin : watchdog
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    modelReset();
    #1;
    // R8: reset state
    check("R8", pout, '0);
    check("R8", {{(W-1){1'b0}}, dataOut}, '0);
    @(negedge clk);
    rstN = 1'b1;

    // Sweep both directions and every latch/blank/polarity combination.
    for (int dr = 0; dr < 2; dr++)
      for (int c = 0; c < 8; c++)
        for (int k = 0; k < 24; k++)
          step(L'($urandom), dr[0], c[0], c[1], c[2]);

    // R9: shifting continues while latches are closed; reopening shows it.
    for (int k = 0; k < 10; k++) step(L'($urandom), 1'b0, 1'b0, 1'b1, 1'b1);
    step(4'hA, 1'b0, 1'b1, 1'b1, 1'b1);
    check("R9", pout, expOut());

    // R3: walking single bit through each lane in forward mode.
    for (int r = 0; r < L; r++)
      for (int k = 0; k < S; k++)
        step((k == 0) ? L'(1 << r) : '0, 1'b0, 1'b1, 1'b1, 1'b1);

    // R8: asynchronous reset in mid-run.
    for (int k = 0; k < 8; k++) step(4'hF, 1'b1, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    modelReset();
    check("R8", pout, '0);
    check("R8", {{(W-1){1'b0}}, dataOut}, '0);
    @(negedge clk);
    rstN = 1'b1;
    step(4'h0, 1'b0, 1'b1, 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule